// File: doc/BRIEF.md
# Five-Source Interrupt Mask Unit

This block sits next to an 8-bit processor core and decides which interrupt the core takes next. Five request pins feed it: a non-maskable input, three maskable vectored restart inputs (named by their priority class 7.5, 6.5 and 5.5), and one general-purpose input whose restart number is supplied with it. The unit holds a global interrupt enable that the core sets and clears with enable and disable commands. It also holds one mask bit for each vectored input and a pending indication for each.

A mask write port loads the three masks and can clear the latched 7.5 request. A status word gives the global enable, the masks and the pending states at all times. The unit picks the highest-priority eligible source and presents its restart address on `irqVector` with `irqValid`. The core accepts it with a one-cycle `irqAck`, which drops the global enable and clears the latch of any edge-captured source that was taken.

Top module: `intr_mask_unit`

## Requirements
- R1: After reset the global enable is 0, all three masks are 1, the 7.5 and non-maskable latches are empty, and `irqValid` is 0.
- R2: `enCmd` sets the global enable and `disCmd` clears it. When both are high in the same cycle, the disable wins.
- R3: A mask write (`maskWr` high) with `maskData[3]`=1 loads `maskData[2]`, `maskData[1]` and `maskData[0]` as the 7.5, 6.5 and 5.5 masks. With `maskData[3]`=0 the masks are left unchanged.
- R4: A mask write with `maskData[4]`=1 empties the 7.5 latch whatever `maskData[3]` is. A rising edge on `r75Req` in the same cycle keeps the latch set.
- R5: `maskStatus` reads as bit 7 = 0, bit 6 = 7.5 pending, bit 5 = 6.5 pending, bit 4 = 5.5 pending, bit 3 = global enable, and bits 2..0 = the 7.5, 6.5 and 5.5 masks.
- R6: A rising edge on `r75Req` sets the 7.5 latch. The latch stays set until it is taken or cleared, and an input held high does not set it again.
- R7: The 6.5 and 5.5 inputs are level sensitive. Their pending bits follow the input pins even while they are masked.
- R8: When several sources are eligible, the priority from highest to lowest is non-maskable, 7.5, 6.5, 5.5, general.
- R9: The vectors are 24h for non-maskable, 3Ch for 7.5, 34h for 6.5, 2Ch for 5.5, and `genNum`×8 for the general input.
- R10: The non-maskable input is captured on a rising edge and is eligible regardless of the global enable and the masks. Taking it empties its latch.
- R11: An accepted `irqAck` (one with `irqValid` high) clears the global enable and overrides an `enCmd` in the same cycle. Taking 7.5 empties its latch, unless a new rising edge arrives in that same cycle.
- R12: A vectored source is eligible only when the global enable is 1 and its mask is 0. The general input needs only the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmiReq | input | 1 | Non-maskable request, edge captured |
| r75Req | input | 1 | Vectored 7.5 request, edge captured |
| r65Req | input | 1 | Vectored 6.5 request, level |
| r55Req | input | 1 | Vectored 5.5 request, level |
| genReq | input | 1 | General request, level |
| genNum | input | 3 | Restart number for the general request |
| enCmd | input | 1 | Set global enable |
| disCmd | input | 1 | Clear global enable |
| maskWr | input | 1 | Mask write strobe |
| maskData | input | 5 | Mask write word: [4] clear 7.5, [3] mask-set-enable, [2:0] masks |
| maskStatus | output | 8 | Enable, mask and pending status word |
| irqValid | output | 1 | An eligible source exists |
| irqVector | output | 16 | Restart address of the winner |
| irqAck | input | 1 | Core accepts the offered interrupt |

## Verification
Two functions can fall in one cycle: the core's acknowledge of a taken 7.5 request and a fresh rising edge on the 7.5 pin, each trying to move the latch in an opposite direction. The bench lowers the pin after the first capture and raises it again on the very cycle of `irqAck`. It then reads the pending bit, which must still be 1, and the enable bit, which must be 0. The same collision is set up between a clearing mask write and an edge, and between `enCmd` and `disCmd` or `irqAck`.

// File: rtl/imu_pkg.sv
package imu_pkg;
  localparam int NSRC    = 5;
  localparam int SRC_NMI = 0;
  localparam int SRC_R75 = 1;
  localparam int SRC_R65 = 2;
  localparam int SRC_R55 = 3;
  localparam int SRC_GEN = 4;
  localparam int SRC_W   = $clog2(NSRC);

  typedef struct packed {
    logic setIe;
    logic clrIe;
    logic loadMask;
    logic set75;
    logic clr75;
    logic setNmi;
    logic clrNmi;
  } imuStrobe_t;
endpackage

// File: rtl/imu_ctrl.sv
module imu_ctrl
  import imu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmiReq,
  input  logic              r75Req,
  input  logic              enCmd,
  input  logic              disCmd,
  input  logic              maskWr,
  input  logic              maskSetEn,
  input  logic              maskClr75,
  input  logic              irqAck,
  input  logic              winValid,
  input  logic [SRC_W-1:0]  winIdx,
  output imuStrobe_t        stb
);
  logic nmiPrev, r75Prev;
  logic ackTaken;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmiPrev <= 1'b0;
      r75Prev <= 1'b0;
    end else begin
      nmiPrev <= nmiReq;
      r75Prev <= r75Req;
    end
  end

  always_comb begin
    ackTaken     = irqAck & winValid;
    stb.clrIe    = disCmd | ackTaken;
    stb.setIe    = enCmd & ~stb.clrIe;
    stb.loadMask = maskWr & maskSetEn;
    stb.set75    = r75Req & ~r75Prev;
    stb.clr75    = (maskWr & maskClr75) |
                   (ackTaken && (winIdx == SRC_W'(SRC_R75)));
    stb.setNmi   = nmiReq & ~nmiPrev;
    stb.clrNmi   = ackTaken && (winIdx == SRC_W'(SRC_NMI));
  end
endmodule

// File: rtl/imu_dp.sv
module imu_dp
  import imu_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int RST_IDX_W = 3,
  parameter int RST_STEP  = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] R75_VEC = 16'h003C,
  parameter logic [VEC_W-1:0] R65_VEC = 16'h0034,
  parameter logic [VEC_W-1:0] R55_VEC = 16'h002C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  imuStrobe_t           stb,
  input  logic [2:0]           maskIn,
  input  logic                 r65Req,
  input  logic                 r55Req,
  input  logic                 genReq,
  input  logic [RST_IDX_W-1:0] genNum,
  output logic                 winValid,
  output logic [SRC_W-1:0]     winIdx,
  output logic [VEC_W-1:0]     irqVector,
  output logic [7:0]           status
);
  localparam int STEP_SH = $clog2(RST_STEP);

  logic       ieReg;
  logic [2:0] maskReg;   // [2]=7.5 [1]=6.5 [0]=5.5
  logic       lat75, latNmi;
  logic [NSRC-1:0] elig;
  logic [VEC_W-1:0] vecTab [NSRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ieReg   <= 1'b0;
      maskReg <= 3'b111;
      lat75   <= 1'b0;
      latNmi  <= 1'b0;
    end else begin
      if (stb.clrIe)         ieReg <= 1'b0;
      else if (stb.setIe)    ieReg <= 1'b1;
      if (stb.loadMask)      maskReg <= maskIn;
      if (stb.set75)         lat75 <= 1'b1;
      else if (stb.clr75)    lat75 <= 1'b0;
      if (stb.setNmi)        latNmi <= 1'b1;
      else if (stb.clrNmi)   latNmi <= 1'b0;
    end
  end

  always_comb begin
    elig[SRC_NMI] = latNmi;
    elig[SRC_R75] = lat75  & ieReg & ~maskReg[2];
    elig[SRC_R65] = r65Req & ieReg & ~maskReg[1];
    elig[SRC_R55] = r55Req & ieReg & ~maskReg[0];
    elig[SRC_GEN] = genReq & ieReg;
    vecTab[SRC_NMI] = NMI_VEC;
    vecTab[SRC_R75] = R75_VEC;
    vecTab[SRC_R65] = R65_VEC;
    vecTab[SRC_R55] = R55_VEC;
    vecTab[SRC_GEN] = VEC_W'(genNum) << STEP_SH;
  end

  // lowest priority first, so the highest eligible index 0 is written last
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
      end
    end
    irqVector = winValid ? vecTab[winIdx] : '0;
  end

  assign status = {1'b0, lat75, r65Req, r55Req, ieReg, maskReg};
endmodule

// File: rtl/intr_mask_unit.sv
module intr_mask_unit
  import imu_pkg::*;
#(
  parameter int VEC_W     = 16,
  parameter int RST_IDX_W = 3,
  parameter int RST_STEP  = 8,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024,
  parameter logic [VEC_W-1:0] R75_VEC = 16'h003C,
  parameter logic [VEC_W-1:0] R65_VEC = 16'h0034,
  parameter logic [VEC_W-1:0] R55_VEC = 16'h002C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 nmiReq,
  input  logic                 r75Req,
  input  logic                 r65Req,
  input  logic                 r55Req,
  input  logic                 genReq,
  input  logic [RST_IDX_W-1:0] genNum,
  input  logic                 enCmd,
  input  logic                 disCmd,
  input  logic                 maskWr,
  input  logic [4:0]           maskData,
  output logic [7:0]           maskStatus,
  output logic                 irqValid,
  output logic [VEC_W-1:0]     irqVector,
  input  logic                 irqAck
);
  imuStrobe_t       stb;
  logic [SRC_W-1:0] winIdx;

  imu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .nmiReq(nmiReq), .r75Req(r75Req),
    .enCmd(enCmd), .disCmd(disCmd), .maskWr(maskWr),
    .maskSetEn(maskData[3]), .maskClr75(maskData[4]),
    .irqAck(irqAck), .winValid(irqValid), .winIdx(winIdx), .stb(stb)
  );

  imu_dp #(
    .VEC_W(VEC_W), .RST_IDX_W(RST_IDX_W), .RST_STEP(RST_STEP),
    .NMI_VEC(NMI_VEC), .R75_VEC(R75_VEC), .R65_VEC(R65_VEC), .R55_VEC(R55_VEC)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .maskIn(maskData[2:0]),
    .r65Req(r65Req), .r55Req(r55Req), .genReq(genReq), .genNum(genNum),
    .winValid(irqValid), .winIdx(winIdx), .irqVector(irqVector),
    .status(maskStatus)
  );
endmodule

// File: rtl/intr_mask_unit_chk.sv
module intr_mask_unit_chk #(
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] NMI_VEC = 16'h0024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             r75Req,
  input logic             disCmd,
  input logic             maskWr,
  input logic [4:0]       maskData,
  input logic [7:0]       maskStatus,
  input logic             irqValid,
  input logic [VEC_W-1:0] irqVector,
  input logic             irqAck
);
  p_reset_state_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (maskStatus[3:0] == 4'h7 && !maskStatus[6] && !irqValid));

  p_dis_clears_ie_r2: assert property (@(posedge clk) disable iff (!rst_n)
    disCmd |=> !maskStatus[3]);

  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (maskWr && !maskData[3]) |=> $stable(maskStatus[2:0]));

  p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r75Req) |=> maskStatus[6]);

  p_nmi_alone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqValid && !maskStatus[3]) |-> (irqVector == NMI_VEC));

  p_ack_clears_ie_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irqAck && irqValid) |=> !maskStatus[3]);
endmodule

bind intr_mask_unit intr_mask_unit_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .r75Req(r75Req), .disCmd(disCmd),
  .maskWr(maskWr), .maskData(maskData), .maskStatus(maskStatus),
  .irqValid(irqValid), .irqVector(irqVector), .irqAck(irqAck)
);

// File: tb/intr_mask_unit_tb.sv
`timescale 1ns/1ps
module intr_mask_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmiReq = 0, r75Req = 0, r65Req = 0, r55Req = 0, genReq = 0;
  logic [2:0] genNum = 0;
  logic enCmd = 0, disCmd = 0, maskWr = 0, irqAck = 0;
  logic [4:0] maskData = 0;
  logic [7:0] maskStatus;
  logic irqValid;
  logic [15:0] irqVector;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intr_mask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .nmiReq(nmiReq), .r75Req(r75Req),
    .r65Req(r65Req), .r55Req(r55Req), .genReq(genReq), .genNum(genNum),
    .enCmd(enCmd), .disCmd(disCmd), .maskWr(maskWr), .maskData(maskData),
    .maskStatus(maskStatus), .irqValid(irqValid), .irqVector(irqVector),
    .irqAck(irqAck)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 0; nmiReq = 0; r75Req = 0; r65Req = 0; r55Req = 0; genReq = 0;
    enCmd = 0; disCmd = 0; maskWr = 0; maskData = 0; irqAck = 0;
    tick(); tick();
    rst_n = 1;
    tick();
  endtask

  task automatic writeMask(input logic [4:0] d);
    maskWr = 1; maskData = d; tick(); maskWr = 0; maskData = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] expVec;
    logic expValid;
    // R1 reset state
    doReset();
    chk("R1 status", maskStatus, 8'h07);
    chk("R1 valid", irqValid, 0);

    // R2 enable, disable, collision
    enCmd = 1; tick(); enCmd = 0;
    chk("R2 enable", maskStatus[3], 1);
    disCmd = 1; tick(); disCmd = 0;
    chk("R2 disable", maskStatus[3], 0);
    enCmd = 1; tick(); enCmd = 0;
    enCmd = 1; disCmd = 1; tick(); enCmd = 0; disCmd = 0;
    chk("R2 both disable wins", maskStatus[3], 0);

    // R3 mask write gating
    writeMask(5'b00_010);
    chk("R3 no set-enable keeps masks", maskStatus[2:0], 3'b111);
    writeMask(5'b01_010);
    chk("R3 masks loaded", maskStatus[2:0], 3'b010);

    // R7 level pending while masked, R5 bit positions
    r65Req = 1; #1;
    chk("R7 6.5 pending while masked", maskStatus[5], 1);
    chk("R5 status word", maskStatus, 8'h22);
    r65Req = 0; r55Req = 1; #1;
    chk("R7 5.5 pending follows pin", maskStatus, 8'h12);
    r55Req = 0;

    // R6 edge latch and no retrigger, R4 clear
    r75Req = 1; tick();
    chk("R6 edge latched", maskStatus[6], 1);
    tick(); tick();
    writeMask(5'b10_000);
    chk("R4 clear bit empties latch", maskStatus[6], 0);
    chk("R4 clear without set-enable keeps masks", maskStatus[2:0], 3'b010);
    tick();
    chk("R6 held level does not retrigger", maskStatus[6], 0);
    r75Req = 0; tick();
    maskWr = 1; maskData = 5'b10_000; r75Req = 1; tick();
    maskWr = 0; maskData = 0;
    chk("R4 edge beats clear", maskStatus[6], 1);
    r75Req = 0; tick();

    // R10 nmi ignores enable and masks
    doReset();
    nmiReq = 1; tick(); nmiReq = 0;
    chk("R10 nmi valid while disabled", irqValid, 1);
    chk("R10 nmi vector", irqVector, 16'h0024);
    irqAck = 1; tick(); irqAck = 0;
    chk("R10 nmi latch emptied by ack", irqValid, 0);

    // R8 nmi beats 7.5; R11 ack clears latch and enable
    writeMask(5'b01_000);
    enCmd = 1; tick(); enCmd = 0;
    r75Req = 1; tick(); r75Req = 0;
    chk("R12 7.5 eligible", irqVector, 16'h003C);
    nmiReq = 1; tick(); nmiReq = 0;
    chk("R8 nmi above 7.5", irqVector, 16'h0024);
    irqAck = 1; tick(); irqAck = 0;
    chk("R11 ack clears enable", maskStatus[3], 0);
    chk("R11 7.5 kept after nmi taken", maskStatus[6], 1);
    enCmd = 1; tick(); enCmd = 0;
    irqAck = 1; enCmd = 1; r75Req = 1; tick(); irqAck = 0; enCmd = 0;
    chk("R11 ack beats enable", maskStatus[3], 0);
    chk("R11 fresh edge survives ack", maskStatus[6], 1);
    r75Req = 0;
    enCmd = 1; tick(); enCmd = 0;
    irqAck = 1; tick(); irqAck = 0;
    chk("R11 ack empties 7.5 latch", maskStatus[6], 0);

    // R8 R9 R12 sweep: enable x masks x latch x levels
    for (int idx = 0; idx < 256; idx++) begin
      logic ie, l75, g, a, b;
      logic [2:0] m;
      ie  = idx[7];
      m   = idx[6:4];
      l75 = idx[3];
      a   = idx[2];
      b   = idx[1];
      g   = idx[0];
      doReset();
      genNum = idx[5:3];
      writeMask({2'b01, m});
      if (ie) begin enCmd = 1; tick(); enCmd = 0; end
      if (l75) begin r75Req = 1; tick(); r75Req = 0; tick(); end
      r65Req = a; r55Req = b; genReq = g; #1;
      expValid = 1; expVec = 0;
      if (ie && l75 && !m[2]) expVec = 16'h003C;
      else if (ie && a && !m[1]) expVec = 16'h0034;
      else if (ie && b && !m[0]) expVec = 16'h002C;
      else if (ie && g) expVec = {13'd0, genNum} * 16'd8;
      else expValid = 0;
      chk("R12 eligibility sweep", irqValid, expValid);
      chk("R8 R9 vector sweep", irqVector, expVec);
      chk("R5 status sweep", maskStatus, {1'b0, l75, a, b, ie, m});
    end

    finishRun();
  end
endmodule